// File: doc/BRIEF.md
# Width-Expanded Dual-Clock FIFO

This block builds one wide first-in first-out buffer out of two identical narrower dual-clock FIFO slices that run side by side. The incoming word is cut into a low field, stored in slice 1, and an upper field, stored in slice 2. The outgoing word is put back together from the two slice outputs. Both slices share the write clock, the read clock, the enables, both resets and the mode select. Each slice keeps its own Gray-coded pointers, its own two-flop synchronizers and its own flags.

The wide FIFO must never offer a word that only one slice holds, and it must never offer space that only one slice has. The two data flags are therefore merged into one, and so are the two space flags. The merge depends on the mode. In standard mode both flags are active-low "empty" and "full" indications, and either slice can assert them. In fall-through mode they are active-low "output ready" and "input ready" indications, and they assert only when both slices agree. The level indications (half full, low water, high water) come from slice 1. A write or read is passed to the slices only when the merged flag allows it, and the same qualified strobe goes to both slices, so their pointers move together.

The mode is captured while the full reset is held, and it stays fixed until the next full reset. The pointer-only reset empties both slices and keeps the captured mode.

Top module: `wfx_wide_fifo`

## Requirements
- R1: `wr_data[LO_W-1:0]` is stored in slice 1 and `wr_data[LO_W+HI_W-1:LO_W]` in slice 2. `rd_data` returns both fields in the same positions, and words leave in the order they were written.
- R2: In standard mode (mode value 0), `data_flag_n` is low while the FIFO is empty. After a read is accepted, the word appears on `rd_data` at the next `rd_clk` rising edge, and `rd_data` holds its value in every cycle with no accepted read.
- R3: In standard mode, `space_flag_n` goes low once DEPTH words are stored. A write attempted while it is low is ignored: no word is lost or overwritten, and the accepted count stays at DEPTH.
- R4: In standard mode, a read attempted while `data_flag_n` is low is ignored: `rd_data` is unchanged and no word is consumed.
- R5: In fall-through mode (mode value 1), the oldest word appears on `rd_data` with `data_flag_n` low and no read request. A read removes that word, and the next one then falls through.
- R6: In fall-through mode the FIFO holds DEPTH+1 words (memory plus output stage). `space_flag_n` is high while no space remains, and writes made then are ignored.
- R7: The merged data flag shows data, and the merged space flag shows space, only when both slices show it. In standard mode this is the AND of the active-low flags; in fall-through mode it is their OR. No data is shown while the FIFO is empty.
- R8: `half_n` is low while the write-side count exceeds DEPTH/2.
- R9: `high_water_n` is low while the write-side count is at least DEPTH-AF_OFS. `low_water_n` is low while the read-side count is at most AE_OFS.
- R10: While `rst_all_n` is low, both slices are emptied and `fall_through` is captured as the mode. Right after the reset, standard mode shows `data_flag_n`=0 and `space_flag_n`=1, and fall-through mode shows `data_flag_n`=1 and `space_flag_n`=0. Changes on `fall_through` after the reset have no effect.
- R11: A low pulse on `rst_ptr_n` empties both slices and sets `rd_data` to 0. It does not change the captured mode, even if `fall_through` changes during the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_all_n | input | 1 | Full reset, active low; empties the slices and captures the mode |
| rst_ptr_n | input | 1 | Pointer reset, active low; empties the slices and keeps the mode |
| fall_through | input | 1 | Mode select captured during full reset (0 standard, 1 fall-through) |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wr_data | input | LO_W+HI_W | Wide input word |
| rd_data | output | LO_W+HI_W | Wide output word |
| data_flag_n | output | 1 | Merged empty (standard) or output-ready (fall-through), active low |
| space_flag_n | output | 1 | Merged full (standard) or input-ready (fall-through), active low |
| half_n | output | 1 | More than half full, active low (slice 1) |
| low_water_n | output | 1 | Almost empty, active low (slice 1) |
| high_water_n | output | 1 | Almost full, active low (slice 1) |

## Verification
The in-line assertions check on every clock edge that no slice is ever written while full or read while empty, that the output word holds when no read is accepted, that each accepted strobe meets both slices' individual flags, and that the captured mode never moves outside full reset. Some behaviour shows only in the bench's scenarios: the field placement and ordering of wide words, the exact capacity in each mode, the level thresholds at their boundary counts, and the mode surviving a pointer reset. The bench covers these with a behavioural queue model that it compares against the ports on every clock.

// File: rtl/wfx_pkg.sv
package wfx_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } wfx_mode_e;

    typedef struct packed {
        logic half_n;
        logic low_n;
        logic high_n;
    } wfx_level_t;

endpackage

// File: rtl/wfx_sync.sv
module wfx_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/wfx_slice.sv
module wfx_slice
    import wfx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int AE_OFS = 2,
    parameter int AF_OFS = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              arst_n,
    input  wfx_mode_e         mode,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              data_n,
    output logic              space_n,
    output wfx_level_t        lvl
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wside_t;

    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic [DATA_W-1:0] dout;
        logic              ov;
    } rside_t;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [DATA_W-1:0] mem [DEPTH];
    wside_t w_d, w_q;
    rside_t r_d, r_q;
    logic [PW-1:0] rgray_w, wgray_r, wcount, rcount;
    logic mem_full, mem_empty, fetch;

    wfx_sync #(.W(PW)) u_r2w (.clk(wclk), .arst_n(arst_n), .d(r_q.gray), .q(rgray_w));
    wfx_sync #(.W(PW)) u_w2r (.clk(rclk), .arst_n(arst_n), .d(w_q.gray), .q(wgray_r));

    // write side
    assign mem_full = (w_q.gray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    assign wcount   = w_q.bin - g2b(rgray_w);

    always_comb begin
        w_d = w_q;
        if (push) begin
            w_d.bin  = w_q.bin + PW'(1);
            w_d.gray = b2g(w_d.bin);
        end
    end

    always_ff @(posedge wclk or negedge arst_n) begin
        if (!arst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    always_ff @(posedge wclk) begin
        if (push) mem[w_q.bin[ADDR_W-1:0]] <= din;
    end

    // read side
    assign mem_empty = (r_q.gray == wgray_r);
    assign rcount    = g2b(wgray_r) - r_q.bin;

    always_comb begin
        r_d = r_q;
        if (mode == MODE_FWFT) fetch = !mem_empty && (!r_q.ov || pop);
        else                   fetch = pop;
        if (fetch) begin
            r_d.bin  = r_q.bin + PW'(1);
            r_d.gray = b2g(r_d.bin);
            r_d.dout = mem[r_q.bin[ADDR_W-1:0]];
        end
        if (mode == MODE_FWFT) begin
            if (fetch)    r_d.ov = 1'b1;
            else if (pop) r_d.ov = 1'b0;
        end else begin
            r_d.ov = 1'b0;
        end
    end

    always_ff @(posedge rclk or negedge arst_n) begin
        if (!arst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    // flags and levels
    assign dout       = r_q.dout;
    assign data_n     = (mode == MODE_FWFT) ? ~r_q.ov  : ~mem_empty;
    assign space_n    = (mode == MODE_FWFT) ? mem_full : ~mem_full;
    assign lvl.half_n = ~(wcount > PW'(DEPTH / 2));
    assign lvl.high_n = ~(wcount >= PW'(DEPTH - AF_OFS));
    assign lvl.low_n  = ~(rcount <= PW'(AE_OFS));

    // R3
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!arst_n)
        push |-> !mem_full);
    // R3
    count_bound_chk: assert property (@(posedge wclk) disable iff (!arst_n)
        wcount <= PW'(DEPTH));
    // R4
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!arst_n)
        (pop && mode == MODE_STD) |-> !mem_empty);
    // R2
    std_hold_chk: assert property (@(posedge rclk) disable iff (!arst_n)
        (mode == MODE_STD && !pop) |=> $stable(dout));
    // R5
    fwft_pop_valid_chk: assert property (@(posedge rclk) disable iff (!arst_n)
        (pop && mode == MODE_FWFT) |-> r_q.ov);
    // R5
    fwft_hold_chk: assert property (@(posedge rclk) disable iff (!arst_n)
        (mode == MODE_FWFT && r_q.ov && !pop) |=> ($stable(dout) && !data_n));
endmodule

// File: rtl/wfx_flag_merge.sv
module wfx_flag_merge
    import wfx_pkg::*;
(
    input  wfx_mode_e mode,
    input  logic      s1_data_n,
    input  logic      s2_data_n,
    input  logic      s1_space_n,
    input  logic      s2_space_n,
    output logic      data_n,
    output logic      space_n,
    output logic      has_data,
    output logic      has_space
);
    always_comb begin
        if (mode == MODE_FWFT) begin
            data_n    = s1_data_n | s2_data_n;
            space_n   = s1_space_n | s2_space_n;
            has_data  = ~data_n;
            has_space = ~space_n;
        end else begin
            data_n    = s1_data_n & s2_data_n;
            space_n   = s1_space_n & s2_space_n;
            has_data  = data_n;
            has_space = space_n;
        end
    end
endmodule

// File: rtl/wfx_wide_fifo.sv
module wfx_wide_fifo
    import wfx_pkg::*;
#(
    parameter int LO_W   = 8,
    parameter int HI_W   = 10,
    parameter int ADDR_W = 4,
    parameter int AE_OFS = 2,
    parameter int AF_OFS = 2,
    localparam int W     = LO_W + HI_W
) (
    input  logic         wr_clk,
    input  logic         rd_clk,
    input  logic         rst_all_n,
    input  logic         rst_ptr_n,
    input  logic         fall_through,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         data_flag_n,
    output logic         space_flag_n,
    output logic         half_n,
    output logic         low_water_n,
    output logic         high_water_n
);
    wfx_mode_e  mode_d, mode_q;
    logic       slice_rst_n, push, pop, has_data, has_space;
    logic       d1_n, d2_n, s1_n, s2_n;
    wfx_level_t lvl1, lvl2_unused;

    always_comb begin
        mode_d = mode_q;
        if (!rst_all_n) mode_d = wfx_mode_e'(fall_through);
    end

    always_ff @(posedge wr_clk) begin
        mode_q <= mode_d;
    end

    assign slice_rst_n = rst_all_n & rst_ptr_n;
    assign push        = wr_en & has_space;
    assign pop         = rd_en & has_data;

    wfx_slice #(.DATA_W(LO_W), .ADDR_W(ADDR_W), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u_lo (
        .wclk(wr_clk), .rclk(rd_clk), .arst_n(slice_rst_n), .mode(mode_q),
        .push(push), .pop(pop), .din(wr_data[LO_W-1:0]), .dout(rd_data[LO_W-1:0]),
        .data_n(d1_n), .space_n(s1_n), .lvl(lvl1));

    wfx_slice #(.DATA_W(HI_W), .ADDR_W(ADDR_W), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u_hi (
        .wclk(wr_clk), .rclk(rd_clk), .arst_n(slice_rst_n), .mode(mode_q),
        .push(push), .pop(pop), .din(wr_data[W-1:LO_W]), .dout(rd_data[W-1:LO_W]),
        .data_n(d2_n), .space_n(s2_n), .lvl(lvl2_unused));

    wfx_flag_merge u_merge (
        .mode(mode_q), .s1_data_n(d1_n), .s2_data_n(d2_n),
        .s1_space_n(s1_n), .s2_space_n(s2_n),
        .data_n(data_flag_n), .space_n(space_flag_n),
        .has_data(has_data), .has_space(has_space));

    assign half_n       = lvl1.half_n;
    assign low_water_n  = lvl1.low_n;
    assign high_water_n = lvl1.high_n;

    // R10
    mode_lock_chk: assert property (@(posedge wr_clk) disable iff (!rst_all_n)
        rst_all_n |=> $stable(mode_q));
    // R7
    composite_data_chk: assert property (@(posedge rd_clk) disable iff (!slice_rst_n)
        pop |-> ((mode_q == MODE_FWFT) ? (!d1_n && !d2_n) : (d1_n && d2_n)));
    // R7
    composite_space_chk: assert property (@(posedge wr_clk) disable iff (!slice_rst_n)
        push |-> ((mode_q == MODE_FWFT) ? (!s1_n && !s2_n) : (s1_n && s2_n)));
endmodule

// File: tb/tb_wfx_wide_fifo.sv
module tb_wfx_wide_fifo;
    localparam int LO_W = 8, HI_W = 10, W = 18, ADDR_W = 4, DEPTH = 16;
    localparam int AE_OFS = 2, AF_OFS = 2;

    logic wclk = 0, rclk = 0;
    always #10 wclk = ~wclk;
    always #15 rclk = ~rclk;

    logic rst_all_n = 0, rst_ptr_n = 1, fall_through = 0, wr_en = 0, rd_en = 0;
    logic [W-1:0] wr_data = '0, rd_data;
    logic data_flag_n, space_flag_n, half_n, low_water_n, high_water_n;

    wfx_wide_fifo #(.LO_W(LO_W), .HI_W(HI_W), .ADDR_W(ADDR_W), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) dut (
        .wr_clk(wclk), .rd_clk(rclk), .rst_all_n(rst_all_n), .rst_ptr_n(rst_ptr_n),
        .fall_through(fall_through), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .rd_data(rd_data), .data_flag_n(data_flag_n), .space_flag_n(space_flag_n),
        .half_n(half_n), .low_water_n(low_water_n), .high_water_n(high_water_n));

    int n_tests = 0, n_fail = 0;
    logic [W-1:0] q[$];
    logic [W-1:0] exp_dout = '0;
    bit fwft_m = 0, mon_en = 0;
    int word_idx = 0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mkword(input int i);
        return {HI_W'(i * 13 + 5), LO_W'(~(i * 7))};
    endfunction

    task automatic push_one(input logic [W-1:0] w, output bit acc);
        @(negedge wclk);
        acc = fwft_m ? !space_flag_n : space_flag_n;
        wr_en = 1; wr_data = w;
        if (acc) q.push_back(w);
        @(posedge wclk); #1 wr_en = 0;
    endtask

    task automatic pop_one(output bit acc);
        logic [W-1:0] w;
        @(negedge rclk);
        acc = fwft_m ? !data_flag_n : data_flag_n;
        rd_en = 1;
        if (acc) begin
            w = q.pop_front();
            if (!fwft_m) exp_dout = w;
        end
        @(posedge rclk); #1 rd_en = 0;
    endtask

    task automatic write_n(input int n, output int accepted);
        bit a;
        accepted = 0;
        for (int i = 0; i < n; i++) begin
            push_one(mkword(word_idx), a);
            word_idx++;
            if (a) accepted++;
        end
    endtask

    task automatic read_n(input int n, output int got);
        bit a;
        got = 0;
        for (int i = 0; i < n; i++) begin
            pop_one(a);
            if (a) got++;
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge wclk);
    endtask

    task automatic full_reset(input bit fw);
        @(negedge wclk);
        mon_en = 0; rst_all_n = 0; fall_through = fw;
        repeat (3) @(negedge wclk);
        q.delete(); exp_dout = '0; fwft_m = fw;
        rst_all_n = 1;
        fall_through = ~fw;
        @(negedge wclk);
        mon_en = 1;
    endtask

    task automatic stream(input int n);
        fork
            begin
                bit a;
                for (int i = 0; i < n; i++) begin
                    a = 0;
                    while (!a) push_one(mkword(word_idx), a);
                    word_idx++;
                    repeat (i % 3) @(negedge wclk);
                end
            end
            begin
                bit a;
                int got = 0;
                while (got < n) begin
                    pop_one(a);
                    if (a) got++;
                end
            end
        join
    endtask

    // per-clock comparison against the queue model, read side
    always @(posedge rclk) begin
        #7;
        if (mon_en) begin
            if (fwft_m) begin
                if (q.size() == 0) check("R7", "fwft data shown while empty", data_flag_n, 1);
                else if (data_flag_n == 0) check("R5", "fwft head word", rd_data, q[0]);
            end else begin
                if (q.size() == 0) check("R7", "std empty flag while empty", data_flag_n, 0);
                check("R2", "std output word", rd_data, exp_dout);
            end
        end
    end

    // per-clock comparison, write side
    always @(posedge wclk) begin
        #3;
        if (mon_en && q.size() >= (fwft_m ? DEPTH + 1 : DEPTH))
            check(fwft_m ? "R6" : "R3", "space flag at capacity", space_flag_n, fwft_m ? 1 : 0);
    end

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int acc, got;
        bit a;
        logic [W-1:0] w;

        // standard mode
        full_reset(0);
        check("R10", "std data flag after reset", data_flag_n, 0);
        check("R10", "std space flag after reset", space_flag_n, 1);
        check("R8", "half flag after reset", half_n, 1);
        check("R9", "low water after reset", low_water_n, 0);
        check("R9", "high water after reset", high_water_n, 1);
        check("R10", "output after reset", rd_data, 0);

        read_n(3, got);
        check("R4", "reads on empty accepted", got, 0);
        check("R4", "output after empty reads", rd_data, 0);

        write_n(5, acc);
        settle();
        check("R2", "std data flag with data", data_flag_n, 1);
        check("R9", "low water at 5", low_water_n, 1);
        w = q[4];
        read_n(5, got);
        check("R2", "reads accepted", got, 5);
        @(negedge rclk);
        check("R1", "low field of last word", rd_data[LO_W-1:0], w[LO_W-1:0]);
        check("R1", "upper field of last word", rd_data[W-1:LO_W], w[W-1:LO_W]);
        settle();
        check("R2", "std empty after drain", data_flag_n, 0);

        // thresholds
        write_n(2, acc); settle();
        check("R9", "low water at AE_OFS", low_water_n, 0);
        write_n(1, acc); settle();
        check("R9", "low water above AE_OFS", low_water_n, 1);
        write_n(5, acc); settle();
        check("R8", "half flag at DEPTH/2", half_n, 1);
        write_n(1, acc); settle();
        check("R8", "half flag above DEPTH/2", half_n, 0);
        write_n(4, acc); settle();
        check("R9", "high water one below", high_water_n, 1);
        write_n(1, acc); settle();
        check("R9", "high water at threshold", high_water_n, 0);
        check("R3", "space flag below capacity", space_flag_n, 1);
        write_n(2, acc); settle();
        check("R3", "space flag at capacity", space_flag_n, 0);
        write_n(3, acc);
        check("R3", "writes accepted while full", acc, 0);
        check("R3", "model depth", q.size(), DEPTH);
        read_n(DEPTH, got);
        check("R3", "words read back after full", got, DEPTH);
        settle();
        check("R2", "empty after draining full", data_flag_n, 0);

        stream(40);
        settle();
        check("R1", "std stream drained", q.size(), 0);

        // pointer reset keeps the mode
        write_n(4, acc);
        @(negedge wclk);
        mon_en = 0; rst_ptr_n = 0; fall_through = 1;
        repeat (3) @(negedge wclk);
        q.delete(); exp_dout = '0;
        rst_ptr_n = 1;
        @(negedge wclk); mon_en = 1;
        settle();
        check("R11", "std empty flag after pointer reset", data_flag_n, 0);
        check("R11", "space flag after pointer reset", space_flag_n, 1);
        check("R11", "output after pointer reset", rd_data, 0);
        write_n(1, acc); settle();
        read_n(1, got);
        check("R11", "std read after pointer reset", got, 1);

        // fall-through mode
        full_reset(1);
        check("R10", "fwft data flag after reset", data_flag_n, 1);
        check("R10", "fwft space flag after reset", space_flag_n, 0);
        write_n(1, acc); settle();
        check("R10", "mode kept after select change", data_flag_n, 0);
        check("R5", "first word without read", rd_data, mkword(word_idx - 1));
        write_n(20, acc);
        check("R6", "extra writes accepted", acc, DEPTH);
        check("R6", "fwft capacity", q.size(), DEPTH + 1);
        settle();
        check("R6", "fwft space flag when full", space_flag_n, 1);
        read_n(DEPTH + 6, got);
        check("R5", "fwft words read", got, DEPTH + 1);
        settle();
        check("R5", "fwft empty after drain", data_flag_n, 1);
        stream(30);
        settle();
        check("R1", "fwft stream drained", q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule